// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

A bank of independent countdown timers sharing one 32-bit register port (address, write strobe, write data, combinational read data). Each channel has its own control, interval and count registers. It picks one of two tick-enable inputs as its time base and divides that tick by a power of two. It counts down once per divided tick. On expiry it either reloads from its interval register (periodic) or stops at zero (one-shot).

A shared enable register and a shared write-one-to-clear status register gate the expiry flags onto a single level-sensitive interrupt line. Software can start a countdown in two ways: write the count directly, or set the reload bit in the control register. The default build has two channels.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: The address map is as follows. The interrupt-enable register is at 0x00, where bit n belongs to channel n. The status register is at 0x04. Channel n has its control register at 0x10*n+0x10, its interval at 0x10*n+0x14 and its count at 0x10*n+0x18. Control bit 0 is enable. Control bit 1 is reload. Control bits 3:2 are the source. Control bits 6:4 are the prescale code. Control bit 7 is one-shot. Control reads back as written, except that bit 1 reads 0. An unmapped address reads 0.
- R3: Writing control with bit 1 set copies the interval into the count, and the bit does not stay set.
- R4: Writing the count register loads that value into the counter.
- R5: While enabled, the count drops by one per divided tick. While disabled, it holds and ignores ticks.
- R6: Source value 1 selects `fast_tick_i`. Values 0, 2 and 3 select `slow_tick_i`.
- R7: Prescale code k makes every 2^k-th selected tick a counting tick. Ticks are counted from the most recent control write.
- R8: A counting tick that finds the count at 1 or 0 is the expiry. On the next cycle status bit n reads 1. In periodic mode the count then equals the interval.
- R9: In one-shot mode, expiry leaves the count at 0 and clears control bit 0. Later ticks change nothing.
- R10: Writing 1 to status bit n clears it, and writing 0 leaves it. If an expiry falls in the same cycle as the clear, the bit stays set.
- R11: `irq_o` is high exactly when some channel has both its status bit and its enable bit set.
- R12: A tick in the same cycle as a write to that channel's control or count register does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| slow_tick_i | input | 1 | Low-speed tick enable |
| fast_tick_i | input | 1 | High-speed tick enable |
| irq_o | output | 1 | Level interrupt |

## Verification
The properties assume that tick inputs are one-cycle pulses synchronous to `clk_i`. They also assume that a write touches exactly one register, selected by a word-aligned address. The status and one-shot properties exclude cycles where software writes the same register the hardware is updating.

The stimulus drives every bus access and tick pulse on the falling edge and holds it for exactly one cycle. It only overlaps a tick with a write in the single case that tests R12.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PRESC_W = 3;
  localparam logic [1:0] SRC_FAST = 2'd1;

  // bit layout of the control register, MSB first
  typedef struct packed {
    logic               oneshot;
    logic [PRESC_W-1:0] presc;
    logic [1:0]         src;
    logic               reload;
    logic               en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  localparam int DIV_W = (1 << CODE_W) - 1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] mask;

  assign mask   = ~({DIV_W{1'b1}} << code_i);
  assign tick_o = tick_i && ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DW    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_tick_i,
  input  logic              fast_tick_i,
  input  logic              ctrl_we_i,
  input  logic              intv_we_i,
  input  logic              cnt_we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  intv_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              en_o,
  output logic              oneshot_o,
  output logic              expire_o
);
  ctrl_t            ctrl_q, ctrl_wr;
  logic [CNT_W-1:0] intv_q, cnt_q;
  logic             sel_tick, ptick, at_end, busy;

  assign ctrl_wr  = ctrl_t'(wdata_i[CTRL_W-1:0]);
  assign sel_tick = (ctrl_q.src == SRC_FAST) ? fast_tick_i : slow_tick_i;
  assign busy     = ctrl_we_i || cnt_we_i;
  assign at_end   = (cnt_q <= CNT_W'(1));
  assign expire_o = ctrl_q.en && ptick && at_end && !busy;

  tmr_prescaler #(.CODE_W(PRESC_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctrl_we_i || !ctrl_q.en),
    .tick_i (sel_tick && ctrl_q.en),
    .code_i (ctrl_q.presc),
    .tick_o (ptick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      intv_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (intv_we_i) intv_q <= wdata_i[CNT_W-1:0];
      if (ctrl_we_i) begin
        ctrl_q        <= ctrl_wr;
        ctrl_q.reload <= 1'b0;
        if (ctrl_wr.reload) cnt_q <= intv_q;
      end else if (cnt_we_i) begin
        cnt_q <= wdata_i[CNT_W-1:0];
      end else if (ctrl_q.en && ptick) begin
        if (!at_end) begin
          cnt_q <= cnt_q - 1'b1;
        end else if (ctrl_q.oneshot) begin
          cnt_q     <= '0;
          ctrl_q.en <= 1'b0;
        end else begin
          cnt_q <= intv_q;
        end
      end
    end
  end

  assign ctrl_o    = ctrl_q;
  assign intv_o    = intv_q;
  assign cnt_o     = cnt_q;
  assign en_o      = ctrl_q.en;
  assign oneshot_o = ctrl_q.oneshot;
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              slow_tick_i,
  input  logic              fast_tick_i,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] IEN_A  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(8'h04);
  localparam int                BLK_W  = ADDR_W - 4;

  logic [NUM_CH-1:0]             ien_q, stat_q, w1c;
  logic [NUM_CH-1:0]             ch_hit, expire, ch_en, ch_oneshot;
  logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_rd;
  logic [NUM_CH-1:0][CNT_W-1:0]  intv_rd, cnt_rd;

  assign w1c = (we_i && addr_i == STAT_A) ? wdata_i[NUM_CH-1:0] : '0;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign ch_hit[n] = (addr_i[ADDR_W-1:4] == BLK_W'(n + 1)) && (addr_i[1:0] == 2'b00);

    tmr_channel #(.CNT_W(CNT_W), .DW(DW)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .slow_tick_i (slow_tick_i),
      .fast_tick_i (fast_tick_i),
      .ctrl_we_i   (we_i && ch_hit[n] && addr_i[3:2] == 2'd0),
      .intv_we_i   (we_i && ch_hit[n] && addr_i[3:2] == 2'd1),
      .cnt_we_i    (we_i && ch_hit[n] && addr_i[3:2] == 2'd2),
      .wdata_i     (wdata_i),
      .ctrl_o      (ctrl_rd[n]),
      .intv_o      (intv_rd[n]),
      .cnt_o       (cnt_rd[n]),
      .en_o        (ch_en[n]),
      .oneshot_o   (ch_oneshot[n]),
      .expire_o    (expire[n])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q  <= '0;
      stat_q <= '0;
    end else begin
      if (we_i && addr_i == IEN_A) ien_q <= wdata_i[NUM_CH-1:0];
      stat_q <= (stat_q & ~w1c) | expire;  // set beats clear
    end
  end

  assign irq_o = |(stat_q & ien_q);

  always_comb begin
    rdata_o = '0;
    if (addr_i == IEN_A) rdata_o[NUM_CH-1:0] = ien_q;
    else if (addr_i == STAT_A) rdata_o[NUM_CH-1:0] = stat_q;
    for (int n = 0; n < NUM_CH; n++) begin
      if (ch_hit[n]) begin
        case (addr_i[3:2])
          2'd0:    rdata_o[CTRL_W-1:0] = ctrl_rd[n];
          2'd1:    rdata_o[CNT_W-1:0]  = intv_rd[n];
          2'd2:    rdata_o[CNT_W-1:0]  = cnt_rd[n];
          default: rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           we_i,
  input logic [ADDR_W-1:0]              addr_i,
  input logic [DW-1:0]                  wdata_i,
  input logic [NUM_CH-1:0]              stat_i,
  input logic [NUM_CH-1:0]              expire_i,
  input logic [NUM_CH-1:0]              en_i,
  input logic [NUM_CH-1:0]              oneshot_i,
  input logic [NUM_CH-1:0][CNT_W-1:0]   cnt_i
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(8'h04);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(16 * n + 16);
    logic clr_n;
    assign clr_n = we_i && addr_i == STAT_A && wdata_i[n];

    a_r8_status_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_i[n] |=> stat_i[n]);

    a_r10_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_n && !expire_i[n]) |=> !stat_i[n]);

    a_r10_status_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_n && !expire_i[n]) |=> $stable(stat_i[n]));

    a_r9_oneshot_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (expire_i[n] && oneshot_i[n] && !(we_i && addr_i == CTRL_A)) |=> !en_i[n]);

    a_r5_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i[n] && !we_i) |=> $stable(cnt_i[n]));
  end
endmodule

bind tick_timer_bank tmr_bank_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DW(DW)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .stat_i    (stat_q),
  .expire_i  (expire),
  .en_i      (ch_en),
  .oneshot_i (ch_oneshot),
  .cnt_i     (cnt_rd)
);

// File: tb/tick_timer_bank_tb.sv
module tick_timer_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        slow = 1'b0, fast = 1'b0;
  logic        irq;
  int          tests = 0, fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  tick_timer_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .slow_tick_i(slow), .fast_tick_i(fast), .irq_o(irq)
  );

  // {write, addr, wdata, expected read}
  localparam int NV = 20;
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'h0,    32'h0},
    {1'b0, 8'h04, 32'h0,    32'h0},
    {1'b0, 8'h10, 32'h0,    32'h0},
    {1'b0, 8'h14, 32'h0,    32'h0},
    {1'b0, 8'h18, 32'h0,    32'h0},
    {1'b0, 8'h28, 32'h0,    32'h0},
    {1'b1, 8'h14, 32'h5,    32'h0},
    {1'b0, 8'h14, 32'h0,    32'h5},
    {1'b1, 8'h10, 32'h2,    32'h0},
    {1'b0, 8'h10, 32'h0,    32'h0},
    {1'b0, 8'h18, 32'h0,    32'h5},
    {1'b1, 8'h28, 32'h1234, 32'h0},
    {1'b0, 8'h28, 32'h0,    32'h1234},
    {1'b1, 8'h20, 32'hF4,   32'h0},
    {1'b0, 8'h20, 32'h0,    32'hF4},
    {1'b0, 8'h0C, 32'h0,    32'h0},
    {1'b1, 8'h00, 32'h3,    32'h0},
    {1'b0, 8'h00, 32'h0,    32'h3},
    {1'b1, 8'h00, 32'h0,    32'h0},
    {1'b0, 8'h00, 32'h0,    32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic tick(input logic f, input logic s);
    @(negedge clk); fast = f; slow = s;
    @(negedge clk); fast = 1'b0; slow = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
      else rd_chk($sformatf("table(R1,R2,R3,R4) vec %0d", i), VEC[i][71:64], VEC[i][31:0]);
    end

    // periodic channel 0, k=0, slow source
    wr(8'h20, 32'h0);
    wr(8'h14, 32'd3);
    wr(8'h10, 32'h03);
    rd_chk("R3 reload", 8'h18, 32'd3);
    tick(1'b0, 1'b1); rd_chk("R5 dec", 8'h18, 32'd2);
    tick(1'b0, 1'b1); rd_chk("R5 dec", 8'h18, 32'd1);
    tick(1'b0, 1'b1); rd_chk("R8 periodic reload", 8'h18, 32'd3);
    rd_chk("R8 status set", 8'h04, 32'h1);
    chk("R11 masked irq", {31'b0, irq}, 32'h0);
    wr(8'h00, 32'h1);
    chk("R11 irq raised", {31'b0, irq}, 32'h1);
    wr(8'h04, 32'h0);
    rd_chk("R10 write 0 keeps", 8'h04, 32'h1);
    wr(8'h04, 32'h1);
    rd_chk("R10 write 1 clears", 8'h04, 32'h0);
    chk("R11 irq dropped", {31'b0, irq}, 32'h0);

    // source select
    tick(1'b1, 1'b0); rd_chk("R6 src0 ignores fast", 8'h18, 32'd3);
    wr(8'h10, 32'h05);
    tick(1'b0, 1'b1); rd_chk("R6 src1 ignores slow", 8'h18, 32'd3);
    tick(1'b1, 1'b0); rd_chk("R6 src1 fast", 8'h18, 32'd2);
    wr(8'h10, 32'h09);
    tick(1'b1, 1'b0); rd_chk("R6 src2 ignores fast", 8'h18, 32'd2);
    tick(1'b0, 1'b1); rd_chk("R6 src2 slow", 8'h18, 32'd1);

    // prescale k=2
    wr(8'h18, 32'd10);
    wr(8'h10, 32'h21);
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1);
    rd_chk("R7 before 4th tick", 8'h18, 32'd10);
    tick(1'b0, 1'b1); rd_chk("R7 4th tick", 8'h18, 32'd9);
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b1);
    rd_chk("R7 8th tick", 8'h18, 32'd8);

    // disabled
    wr(8'h10, 32'h0);
    tick(1'b0, 1'b1); tick(1'b1, 1'b1);
    rd_chk("R5 disabled holds", 8'h18, 32'd8);

    // tick coincides with count write
    wr(8'h10, 32'h01);
    @(negedge clk); we = 1'b1; addr = 8'h18; wdata = 32'd7; slow = 1'b1;
    @(negedge clk); we = 1'b0; slow = 1'b0;
    rd_chk("R12 tick during write", 8'h18, 32'd7);
    tick(1'b0, 1'b1); rd_chk("R12 next tick counts", 8'h18, 32'd6);

    // one-shot on channel 1
    wr(8'h10, 32'h0);
    wr(8'h28, 32'd2);
    wr(8'h20, 32'h81);
    tick(1'b0, 1'b1); tick(1'b0, 1'b1);
    rd_chk("R9 count zero", 8'h28, 32'd0);
    rd_chk("R9 enable cleared", 8'h20, 32'h80);
    rd_chk("R8 ch1 status", 8'h04, 32'h2);
    wr(8'h04, 32'h2);
    tick(1'b0, 1'b1);
    rd_chk("R9 stays at zero", 8'h28, 32'd0);
    rd_chk("R9 no new status", 8'h04, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule